// File: doc/BRIEF.md
# Interrupt Pin Request and EOI Service Logic

This block tracks request state for a set of interrupt input pins and decides when each one is serviced. Servicing a pin means offering its index to a downstream delivery stage. For each pin it takes the raw pin level and three per-entry settings: an inversion bit, a trigger-mode bit and a mask bit. It also takes an 8-bit-style vector that is compared against end-of-interrupt (EOI) notifications. Destination resolution happens downstream. The delivery stage answers each offer with a ready strobe and an accepted flag.

Edge-mode pins request once for each rising transition of their effective level. Level-mode pins request for as long as their effective level is high. An accepted delivery sets a per-pin remote-IRR flag on a level-mode pin. That flag blocks further deliveries from the pin until an EOI whose vector matches the pin's configured vector arrives. After the EOI, a pin whose input is still asserted is offered again. When several pins are eligible, the lowest pin index is offered first, one pin at a time.

Top module: `irq_pin_service`

## Requirements
- R1: After reset `dlv_valid` is low, and every pin's request and remote-IRR state is clear, so no offer appears while all effective levels stay low.
- R2: A pin's effective level is its raw level XOR its `pin_polarity` bit. With polarity 1, a falling raw level is an asserting transition.
- R3: An edge-mode pin (`pin_level_trig` bit = 0) is offered once per rising transition of its effective level. Holding the level high produces no further offers.
- R4: A level-mode pin (`pin_level_trig` bit = 1) with a high effective level and a clear remote-IRR flag is offered. An accepted delivery (`dlv_accepted`=1 in the ready cycle) sets its remote-IRR flag, and no further offers come from that pin while the flag is set.
- R5: A refused delivery (`dlv_accepted`=0) of a level-mode pin leaves remote-IRR clear, so the pin is offered again. A refused edge-mode delivery is dropped.
- R6: An effective level that goes low clears the pin's request. A pin that asserts and deasserts while another offer is outstanding is never delivered.
- R7: A pin whose `pin_mask` bit is 1 is never offered. A level-mode pin that is still asserted when it is unmasked is offered.
- R8: A one-cycle `eoi_valid` clears remote-IRR on every pin whose configured vector equals `eoi_vector`. Pins that are still asserted and unmasked are then offered again. Pins with other vectors are unaffected.
- R9: Among eligible pins, the lowest index is offered first. Simultaneous requests are delivered in ascending index order.
- R10: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid` and `dlv_pin` hold steady. After every handshake, `dlv_valid` is low for the next cycle.
- R11: If an EOI matching a pin and an accepted delivery of that same level-mode pin occur in the same cycle, the pin's remote-IRR flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_PINS | Raw interrupt pin levels |
| pin_polarity | input | NUM_PINS | Per-pin inversion bit (1 = active low) |
| pin_level_trig | input | NUM_PINS | Per-pin trigger mode (1 = level, 0 = edge) |
| pin_mask | input | NUM_PINS | Per-pin mask (1 = masked) |
| pin_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery offer valid |
| dlv_pin | output | IDX_W | Index of the offered pin |
| dlv_ready | input | 1 | Delivery stage takes the offer this cycle |
| dlv_accepted | input | 1 | Delivery succeeded, sampled with `dlv_ready` |

## Verification
The bench builds the block with NUM_PINS=5 and VEC_W=4. Five pins are enough to mix both trigger modes, an inverted pin, and a pair of pins that share one vector, so that a single EOI releases two pins at once. A non-power-of-two pin count also exercises an index field with unused codes. The narrow vector keeps EOI matching cheap to drive.

// File: rtl/irq_svc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the interrupt pin service logic.
// Assumes nothing beyond IEEE 1800-2017.
package irq_svc_pkg;

    // Trigger mode of one pin entry.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/irq_pin_slot.sv
`timescale 1ns/1ps
// Module: irq_pin_slot
// Holds the request, remote-IRR and edge-history state of one interrupt pin
// and raises 'want' when the pin is eligible for a delivery offer.
// Assumes 'served' is high for exactly the cycle in which the delivery stage
// takes an offer for this pin, and 'accepted' is valid in that cycle.
module irq_pin_slot
    import irq_svc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_lvl,
    input  logic             polarity,
    input  logic             trig,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             served,
    input  logic             accepted,
    output logic             want
);

    logic eff;
    logic is_level;
    logic eoi_hit;
    logic lvl_q;
    logic req_q;
    logic rirr_q;

    // Qualify the raw level and decode per-pin controls.
    always_comb begin
        eff      = raw_lvl ^ polarity;
        is_level = (trig_e'(trig) == TRIG_LEVEL);
        eoi_hit  = eoi_valid && (eoi_vector == vector);
    end

    // Track previous effective level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= eff;
    end

    // Request bit: follows the level in level mode, latches rising edges in edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (is_level) begin
            req_q <= eff;
        end else if (!eff) begin
            req_q <= 1'b0;
        end else if (!lvl_q && !mask) begin
            req_q <= 1'b1;
        end else if (served) begin
            req_q <= 1'b0;
        end
    end

    // Remote-IRR: set by an accepted level delivery, cleared by a matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rirr_q <= 1'b0;
        end else if (served && accepted && is_level) begin
            rirr_q <= 1'b1;
        end else if (eoi_hit) begin
            rirr_q <= 1'b0;
        end
    end

    // Eligibility for an offer.
    always_comb begin
        want = req_q && !mask && !(is_level && rirr_q);
    end

    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_vector == vector && !(served && accepted && trig)) |=> !rirr_q);

    // R11
    eoi_vs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (served && accepted && trig) |=> rirr_q);

    // R6
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_lvl ^ polarity) |=> !req_q);

endmodule

// File: rtl/irq_first_set.sv
`timescale 1ns/1ps
// Module: irq_first_set
// Finds the lowest set bit of a request vector; combinational.
// Assumes WIDTH >= 1; 'idx' is zero when no bit is set.
module irq_first_set #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_offer_reg.sv
`timescale 1ns/1ps
// Module: irq_offer_reg
// Registers the delivery offer (valid + pin index) and holds it until the
// delivery stage raises ready; leaves one idle cycle after each handshake.
// Assumes 'any'/'idx' come from the current eligibility state.
module irq_offer_reg #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [IDX_W-1:0] idx,
    input  logic             ready,
    output logic             valid,
    output logic [IDX_W-1:0] pin
);

    // Offer state: load when idle, hold while waiting, drop on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            pin   <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (any) begin
            valid <= 1'b1;
            pin   <= idx;
        end
    end

    // R10
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(pin)));

    // R10
    gap_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);

endmodule

// File: rtl/irq_pin_service.sv
`timescale 1ns/1ps
// Module: irq_pin_service (top)
// Per-pin interrupt request and EOI logic: qualifies pin levels, keeps
// request and remote-IRR state per pin, and offers eligible pins one at a
// time, lowest index first, over a valid/ready delivery handshake.
// Assumes dlv_accepted is meaningful only in a cycle with dlv_valid && dlv_ready.
module irq_pin_service #(
    parameter int NUM_PINS = 8,
    parameter int VEC_W    = 8,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_level,
    input  logic [NUM_PINS-1:0]       pin_polarity,
    input  logic [NUM_PINS-1:0]       pin_level_trig,
    input  logic [NUM_PINS-1:0]       pin_mask,
    input  logic [NUM_PINS*VEC_W-1:0] pin_vector,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      dlv_valid,
    output logic [IDX_W-1:0]          dlv_pin,
    input  logic                      dlv_ready,
    input  logic                      dlv_accepted
);

    localparam logic [NUM_PINS-1:0] ONE = NUM_PINS'(1);

    logic [NUM_PINS-1:0] want_vec;
    logic [NUM_PINS-1:0] served_vec;
    logic                pick_any;
    logic [IDX_W-1:0]    pick_idx;

    // Decode which pin the current handshake completes.
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            served_vec[i] = dlv_valid && dlv_ready && (dlv_pin == IDX_W'(i));
        end
    end

    // One state slot per pin.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
        irq_pin_slot #(.VEC_W(VEC_W)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_lvl    (pin_level[g]),
            .polarity   (pin_polarity[g]),
            .trig       (pin_level_trig[g]),
            .mask       (pin_mask[g]),
            .vector     (pin_vector[g*VEC_W +: VEC_W]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .served     (served_vec[g]),
            .accepted   (dlv_accepted),
            .want       (want_vec[g])
        );
    end

    irq_first_set #(.WIDTH(NUM_PINS)) i_pick (
        .vec (want_vec),
        .any (pick_any),
        .idx (pick_idx)
    );

    irq_offer_reg #(.IDX_W(IDX_W)) i_offer (
        .clk   (clk),
        .rst_n (rst_n),
        .any   (pick_any),
        .idx   (pick_idx),
        .ready (dlv_ready),
        .valid (dlv_valid),
        .pin   (dlv_pin)
    );

    // R9
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) |-> (($past(want_vec) & ((ONE << dlv_pin) - ONE)) == '0));

    // R7
    masked_not_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) |-> (($past(pin_mask) & (ONE << dlv_pin)) == '0));

    // R9
    offer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (int'(dlv_pin) < NUM_PINS));

endmodule

// File: tb/test_irq_pin_service.sv
`timescale 1ns/1ps
// Bench for irq_pin_service: behavioural reference model compared every cycle,
// plus directed scenarios with delivery counts and order.
module test_irq_pin_service;

    localparam int NP    = 5;
    localparam int VW    = 4;
    localparam int IW    = $clog2(NP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pin_level = '0;
    logic [NP-1:0]   pin_polarity = '0;
    logic [NP-1:0]   pin_level_trig = '0;
    logic [NP-1:0]   pin_mask = '0;
    logic [NP*VW-1:0] pin_vector = '0;
    logic            eoi_valid = 1'b0;
    logic [VW-1:0]   eoi_vector = '0;
    logic            dlv_valid;
    logic [IW-1:0]   dlv_pin;
    logic            dlv_ready = 1'b0;
    logic            dlv_accepted = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt[NP];
    int order_q[$];
    bit done = 1'b0;

    // reference model state
    bit m_lvl[NP];
    bit m_req[NP];
    bit m_rirr[NP];
    bit m_valid;
    int m_pin;

    irq_pin_service #(.NUM_PINS(NP), .VEC_W(VW)) i_irq_pin_service (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_polarity(pin_polarity),
        .pin_level_trig(pin_level_trig), .pin_mask(pin_mask), .pin_vector(pin_vector),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
        .dlv_pin(dlv_pin), .dlv_ready(dlv_ready), .dlv_accepted(dlv_accepted)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_want(input int i);
        bit lvl_mode = pin_level_trig[i];
        return m_req[i] && !pin_mask[i] && !(lvl_mode && m_rirr[i]);
    endfunction

    // Reference model, updated at each rising edge from inputs and model state.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_lvl[i] = 0; m_req[i] = 0; m_rirr[i] = 0;
            end
            m_valid = 0; m_pin = 0;
        end else begin
            int pick;
            bit hs;
            pick = -1;
            hs = m_valid && dlv_ready;
            if (!m_valid)
                for (int i = NP - 1; i >= 0; i--) if (m_want(i)) pick = i;
            for (int i = 0; i < NP; i++) begin
                bit e;
                bit srv;
                bit lm;
                e   = pin_level[i] ^ pin_polarity[i];
                srv = hs && (m_pin == i);
                lm  = pin_level_trig[i];
                if (srv && dlv_accepted && lm) m_rirr[i] = 1;
                else if (eoi_valid && eoi_vector == pin_vector[i*VW +: VW]) m_rirr[i] = 0;
                if (lm) m_req[i] = e;
                else if (!e) m_req[i] = 0;
                else if (!m_lvl[i] && !pin_mask[i]) m_req[i] = 1;
                else if (srv) m_req[i] = 0;
                m_lvl[i] = e;
            end
            if (m_valid) begin
                if (dlv_ready) m_valid = 0;
            end else if (pick >= 0) begin
                m_valid = 1; m_pin = pick;
            end
        end
    end

    // Compare with model and log handshakes, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dlv_valid == m_valid, "R10 offer valid vs model", int'(dlv_valid), int'(m_valid));
            if (m_valid) chk(int'(dlv_pin) == m_pin, "R9 offer pin vs model", int'(dlv_pin), m_pin);
            if (dlv_valid && dlv_ready) begin
                cnt[dlv_pin]++;
                order_q.push_back(int'(dlv_pin));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic eoi(input int v);
        eoi_valid = 1'b1; eoi_vector = VW'(v);
        step(1);
        eoi_valid = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        int b0, b3, b4;
        for (int i = 0; i < NP; i++) cnt[i] = 0;
        // pin0 edge, pins1-3 level, pin4 edge inverted; pins 1 and 2 share vector 5
        pin_level_trig = 5'b01110;
        pin_polarity   = 5'b10000;
        pin_vector     = {4'd9, 4'd7, 4'd5, 4'd5, 4'd3};
        pin_level      = 5'b10000;
        step(3);
        chk(dlv_valid == 1'b0, "R1 valid in reset", int'(dlv_valid), 0);
        rst_n = 1'b1;
        step(4);
        chk(dlv_valid == 1'b0, "R1 idle after reset", int'(dlv_valid), 0);

        // R9: simultaneous level requests, ascending order
        pin_level[3:1] = 3'b111;
        step(4);
        chk(dlv_valid && dlv_pin == 1, "R9 first offer is lowest", int'(dlv_pin), 1);
        dlv_ready = 1'b1; dlv_accepted = 1'b1;
        step(10);
        chk(order_q.size() == 3, "R9 delivery count", order_q.size(), 3);
        if (order_q.size() == 3) begin
            chk(order_q[0] == 1 && order_q[1] == 2 && order_q[2] == 3, "R9 order 1,2,3",
                order_q[0] * 100 + order_q[1] * 10 + order_q[2], 123);
        end
        step(10);
        // R4: remote-IRR blocks repeat delivery
        chk(cnt[1] == 1 && cnt[2] == 1 && cnt[3] == 1, "R4 no repeat while remote-IRR set",
            cnt[1] + cnt[2] + cnt[3], 3);
        pin_level[3:1] = 3'b000;
        step(2);
        eoi(5); eoi(7);
        step(5);
        chk(cnt[1] + cnt[2] + cnt[3] == 3, "R6 EOI with low level delivers nothing",
            cnt[1] + cnt[2] + cnt[3], 3);

        // R3: edge pin
        pin_level[0] = 1'b1;
        step(20);
        chk(cnt[0] == 1, "R3 one delivery per rising edge", cnt[0], 1);
        pin_level[0] = 1'b0; step(2); pin_level[0] = 1'b1;
        step(10);
        chk(cnt[0] == 2, "R3 second rising edge", cnt[0], 2);

        // R2: inverted edge pin asserted by falling raw level
        pin_level[4] = 1'b0;
        step(10);
        chk(cnt[4] == 1, "R2 inverted pin delivered", cnt[4], 1);

        // R8: shared vector EOI releases pins 1 and 2 only
        pin_level[3:1] = 3'b111;
        step(12);
        chk(cnt[1] == 2 && cnt[2] == 2 && cnt[3] == 2, "R4 level pins delivered again",
            cnt[1] + cnt[2] + cnt[3], 6);
        eoi(5);
        step(12);
        chk(cnt[1] == 3 && cnt[2] == 3, "R8 matching pins redelivered", cnt[1] + cnt[2], 6);
        chk(cnt[3] == 2, "R8 non-matching pin unaffected", cnt[3], 2);
        eoi(7);
        step(8);
        chk(cnt[3] == 3, "R8 pin3 released by its vector", cnt[3], 3);
        pin_level[3:1] = 3'b000;
        step(2);
        eoi(5); eoi(7);

        // R5: refused level delivery retried, refused edge delivery dropped
        dlv_accepted = 1'b0;
        base = cnt[3];
        pin_level[3] = 1'b1;
        step(12);
        chk(cnt[3] - base >= 2, "R5 refused level pin retried", cnt[3] - base, 2);
        dlv_accepted = 1'b1;
        step(6);
        base = cnt[3];
        step(10);
        chk(cnt[3] == base, "R5 accepted delivery stops retries", cnt[3], base);
        pin_level[3] = 1'b0;
        step(2);
        eoi(7);
        dlv_accepted = 1'b0;
        base = cnt[0];
        pin_level[0] = 1'b0; step(2); pin_level[0] = 1'b1;
        step(12);
        chk(cnt[0] - base == 1, "R5 refused edge dropped", cnt[0] - base, 1);
        dlv_accepted = 1'b1;

        // R6: pulses during an outstanding offer are lost
        dlv_ready = 1'b0;
        b0 = cnt[0]; b3 = cnt[3]; b4 = cnt[4];
        pin_level[0] = 1'b0; step(2); pin_level[0] = 1'b1;
        step(3);
        chk(dlv_valid && dlv_pin == 0, "R10 offer waiting for ready", int'(dlv_pin), 0);
        pin_level[3] = 1'b1; step(2); pin_level[3] = 1'b0;
        pin_level[4] = 1'b1; step(2); pin_level[4] = 1'b0; step(2); pin_level[4] = 1'b1;
        step(2);
        chk(dlv_valid && dlv_pin == 0, "R10 offer held stable", int'(dlv_pin), 0);
        dlv_ready = 1'b1;
        step(10);
        chk(cnt[0] - b0 == 1, "R6 held pin delivered", cnt[0] - b0, 1);
        chk(cnt[3] == b3 && cnt[4] == b4, "R6 deasserted pins not delivered",
            (cnt[3] - b3) + (cnt[4] - b4), 0);

        // R7: masked level pin, then unmasked
        pin_mask[2] = 1'b1;
        base = cnt[2];
        pin_level[2] = 1'b1;
        step(10);
        chk(cnt[2] == base, "R7 masked pin not offered", cnt[2], base);
        pin_mask[2] = 1'b0;
        step(10);
        chk(cnt[2] == base + 1, "R7 unmasked asserted pin offered", cnt[2], base + 1);
        pin_level[2] = 1'b0;
        step(2);
        eoi(5);

        // R11: EOI and accepted delivery of the same pin in one cycle
        dlv_ready = 1'b0;
        base = cnt[3];
        pin_level[3] = 1'b1;
        step(4);
        chk(dlv_valid && dlv_pin == 3, "R11 pin3 offered", int'(dlv_pin), 3);
        dlv_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 4'd7;
        step(1);
        eoi_valid = 1'b0;
        step(12);
        chk(cnt[3] - base == 1, "R11 remote-IRR wins over same-cycle EOI", cnt[3] - base, 1);
        pin_level[3] = 1'b0;
        step(4);
        finish_run();
    end

endmodule